// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator CPU. Each cycle it may receive the current accumulator value, a second 8-bit operand and a 4-bit operation code. When the valid strobe is high, it registers a new result byte and a new flag byte on the next rising clock edge. The surrounding core writes `result_q` back to the accumulator and returns `flags_q` as the current flag state.

The flag byte has a fixed layout. Zero is in bit 7, subtract is in bit 6, half-carry is in bit 5 and carry is in bit 4. Bits 3 to 0 always read as zero. Each operation has its own flag policy:

- Increment and decrement keep the carry.
- The logical AND forces the half-carry.
- Compare updates the flags and discards its difference.
- The carry-only operations leave Z alone.

The flag register can also be reloaded from a byte popped off the stack. Its low nibble is dropped on that path.

Top module: `acc_alu8`

## Requirements
- R1: After a synchronous active-high reset, `result_q` and `flags_q` are 0x00. Bits 3..0 of `flags_q` are zero at all times. The layout is Z=bit7, N=bit6, H=bit5, C=bit4.
- R2: Code 0x0 (add) sets result = acc+opnd. It clears N, sets H on a carry out of bit 3, sets C on a carry out of bit 7, and sets Z when the 8-bit result is zero.
- R3: Code 0x1 (add with carry) adds the incoming C into the same sum. H and C are taken over the whole 9-bit sum, so 0x00+0xFF with C=1 gives result 0x00 and flags 0xB0.
- R4: Code 0x2 (subtract) and code 0x3 (subtract with borrow, which also subtracts the incoming C) set result = acc-opnd[-C]. They set N, set H on a borrow from the low nibble, set C on a borrow out of bit 7, and set Z when the result is zero. For example, 0x00-0xFF with C=1 gives result 0x00 and flags 0xF0.
- R5: Code 0x4 (compare) sets the flags exactly as subtract does and loads `result_q` with the unchanged accumulator input.
- R6: Code 0x5 (AND) sets H and clears N and C. Codes 0x6 (OR) and 0x7 (XOR) clear N, H and C. All three set Z only when the result is zero.
- R7: Code 0x8 (increment acc) keeps C and clears N. It sets H when the low nibble of the result is 0x0, and sets Z when the result is zero.
- R8: Code 0x9 (decrement acc) keeps C and sets N. It sets H when the low nibble of the result is 0xF, and sets Z when the result is zero.
- R9: Code 0xA (complement) sets result = ~acc, sets N and H, and keeps Z and C.
- R10: Code 0xB (set carry) sets C, and code 0xC (complement carry) inverts C. Both clear N and H, keep Z, and pass acc to the result unchanged.
- R11: When `flag_pop` is high, `flags_q` loads `{flag_pop_byte[7:4],4'b0000}` on the next edge. In that cycle any operation is ignored and `result_q` holds its value.
- R12: With `op_valid` low, or with an unused code 0xD..0xF, both `result_q` and `flags_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| flag_pop | input | 1 | Load flag byte from the stack path |
| flag_pop_byte | input | 8 | Popped flag byte |
| result_q | output | 8 | Registered result |
| flags_q | output | 8 | Registered flag byte |

## Verification
The hardest cases to reach are the carry-dependent boundaries. Add with carry must wrap because of the incoming carry alone, as with operand 0xFF and C=1. Subtract with borrow has the matching case where the borrow comes from the carry term. Both need a known C in the flag register before the operation runs. The bench therefore first runs a set-carry, clear-carry or flag pop, and only then issues the add or subtract with the boundary operands. A strided sweep over both operands and every code then chains each operation off the flags left by the one before. This exercises the preserved-carry and kept-Z paths from many starting flag states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W  = 8;
    localparam int NIB_W  = 4;
    localparam int FLAG_W = 8;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD = 4'h0,
        OP_ADC = 4'h1,
        OP_SUB = 4'h2,
        OP_SBC = 4'h3,
        OP_CMP = 4'h4,
        OP_AND = 4'h5,
        OP_OR  = 4'h6,
        OP_XOR = 4'h7,
        OP_INC = 4'h8,
        OP_DEC = 4'h9,
        OP_CPL = 4'hA,
        OP_SCF = 4'hB,
        OP_CCF = 4'hC
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

    typedef struct packed {
        logic             hit;
        logic [ALU_W-1:0] res;
        flag_t            fl;
    } alu_next_t;

    function automatic logic [FLAG_W-1:0] pack_flags(input flag_t f);
        return {f, {(FLAG_W-4){1'b0}}};
    endfunction

    function automatic flag_t unpack_flags(input logic [FLAG_W-1:0] b);
        return flag_t'(b[FLAG_W-1 -: 4]);
    endfunction

    function automatic logic is_zero(input logic [ALU_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] b,
    input  logic             carry_in,
    input  logic             use_carry,
    input  logic             subtract,
    output logic [ALU_W-1:0] sum,
    output logic             half,
    output logic             carry
);
    logic [ALU_W-1:0] b_eff;
    logic             c_eff;
    logic [NIB_W:0]   low_sum;
    logic [ALU_W:0]   full_sum;

    always_comb begin
        b_eff    = subtract ? ~b : b;
        c_eff    = subtract ? ~(use_carry & carry_in) : (use_carry & carry_in);
        low_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{ALU_W{1'b0}}, c_eff};
        sum      = full_sum[ALU_W-1:0];
        // carry out of an inverted-operand sum means "no borrow"
        half     = low_sum[NIB_W] ^ subtract;
        carry    = full_sum[ALU_W] ^ subtract;
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] b,
    input  logic_sel_e       sel,
    output logic [ALU_W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_state.sv
module alu8_state
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  alu_next_t         nxt,
    input  logic              pop,
    input  logic [FLAG_W-1:0] pop_byte,
    output logic [ALU_W-1:0]  result_q,
    output logic [FLAG_W-1:0] flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (pop) begin
            flags_q  <= pack_flags(unpack_flags(pop_byte));
        end else if (upd && nxt.hit) begin
            result_q <= nxt.res;
            flags_q  <= pack_flags(nxt.fl);
        end
    end

    p_low_nibble_zero_r1: assert property (@(posedge clk) disable iff (rst)
        flags_q[3:0] == 4'h0);

    p_pop_masked_r11: assert property (@(posedge clk) disable iff (rst)
        pop |=> (flags_q == {$past(pop_byte[7:4]), 4'h0}) && $stable(result_q));
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic [7:0] acc_in,
    input  logic [7:0] opnd_in,
    input  logic       flag_pop,
    input  logic [7:0] flag_pop_byte,
    output logic [7:0] result_q,
    output logic [7:0] flags_q
);
    alu_op_e          op;
    flag_t            cur;
    logic             main_sub, main_cin;
    logic [ALU_W-1:0] main_sum, step_sum, lg_y;
    logic             main_h, main_c, step_h, step_c;
    logic_sel_e       lg_sel;
    alu_next_t        nxt;

    assign op  = alu_op_e'(op_code);
    assign cur = unpack_flags(flags_q);

    assign main_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign main_cin = (op == OP_ADC) || (op == OP_SBC);

    always_comb begin
        unique case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_NOT;
        endcase
    end

    alu8_addsub u_main (
        .a(acc_in), .b(opnd_in), .carry_in(cur.c), .use_carry(main_cin),
        .subtract(main_sub), .sum(main_sum), .half(main_h), .carry(main_c)
    );

    // increment/decrement path: operand zero, forced unit carry-in
    alu8_addsub u_step (
        .a(acc_in), .b('0), .carry_in(1'b1), .use_carry(1'b1),
        .subtract(op == OP_DEC), .sum(step_sum), .half(step_h), .carry(step_c)
    );

    alu8_logic u_logic (
        .a(acc_in), .b(opnd_in), .sel(lg_sel), .y(lg_y)
    );

    always_comb begin
        nxt.hit = 1'b1;
        nxt.res = acc_in;
        nxt.fl  = cur;
        case (op)
            OP_ADD, OP_ADC: begin
                nxt.res = main_sum;
                nxt.fl  = '{z: is_zero(main_sum), n: 1'b0, h: main_h, c: main_c};
            end
            OP_SUB, OP_SBC: begin
                nxt.res = main_sum;
                nxt.fl  = '{z: is_zero(main_sum), n: 1'b1, h: main_h, c: main_c};
            end
            OP_CMP: begin
                nxt.fl  = '{z: is_zero(main_sum), n: 1'b1, h: main_h, c: main_c};
            end
            OP_AND: begin
                nxt.res = lg_y;
                nxt.fl  = '{z: is_zero(lg_y), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_OR, OP_XOR: begin
                nxt.res = lg_y;
                nxt.fl  = '{z: is_zero(lg_y), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_INC, OP_DEC: begin
                nxt.res = step_sum;
                nxt.fl  = '{z: is_zero(step_sum), n: (op == OP_DEC), h: step_h, c: cur.c};
            end
            OP_CPL: begin
                nxt.res = lg_y;
                nxt.fl  = '{z: cur.z, n: 1'b1, h: 1'b1, c: cur.c};
            end
            OP_SCF: nxt.fl = '{z: cur.z, n: 1'b0, h: 1'b0, c: 1'b1};
            OP_CCF: nxt.fl = '{z: cur.z, n: 1'b0, h: 1'b0, c: ~cur.c};
            default: nxt.hit = 1'b0;
        endcase
    end

    alu8_state u_state (
        .clk(clk), .rst(rst), .upd(op_valid), .nxt(nxt),
        .pop(flag_pop), .pop_byte(flag_pop_byte),
        .result_q(result_q), .flags_q(flags_q)
    );

    p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_pop && op_code == 4'h4)
        |=> (result_q == $past(acc_in)) && flags_q[6]);

    p_and_forces_h_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_pop && op_code == 4'h5)
        |=> flags_q[5] && !flags_q[6] && !flags_q[4]);

    p_inc_keeps_c_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_pop && op_code == 4'h8)
        |=> (flags_q[4] == $past(flags_q[4])) && !flags_q[6]);

    p_dec_keeps_c_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_pop && op_code == 4'h9)
        |=> (flags_q[4] == $past(flags_q[4])) && flags_q[6]);

    p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (!flag_pop && (!op_valid || op_code > 4'hC))
        |=> $stable(result_q) && $stable(flags_q));
endmodule

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'h0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic       flag_pop = 1'b0;
    logic [7:0] flag_pop_byte = 8'h00;
    logic [7:0] result_q, flags_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_res = 8'h00;
    logic [7:0] exp_flg = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu8 u_acc_alu8 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .flag_pop(flag_pop),
        .flag_pop_byte(flag_pop_byte), .result_q(result_q), .flags_q(flags_q)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // reference model: returns {hit, result, flags}
    function automatic logic [16:0] model(input logic [3:0] code, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        int s, lo, cin, z, n, h, c, r;
        logic hit;
        cin = int'(f[4]);
        z = int'(f[7]); n = int'(f[6]); h = int'(f[5]); c = int'(f[4]);
        r = int'(a); hit = 1'b1;
        case (code)
            4'h0, 4'h1: begin
                if (code == 4'h0) cin = 0;
                s = int'(a) + int'(b) + cin;
                lo = int'(a & 8'h0F) + int'(b & 8'h0F) + cin;
                r = s & 255; n = 0; h = (lo > 15); c = (s > 255); z = (r == 0);
            end
            4'h2, 4'h3, 4'h4: begin
                if (code != 4'h3) cin = 0;
                s = int'(a) - int'(b) - cin;
                lo = int'(a & 8'h0F) - int'(b & 8'h0F) - cin;
                n = 1; h = (lo < 0); c = (s < 0); z = ((s & 255) == 0);
                if (code != 4'h4) r = s & 255;
            end
            4'h5: begin r = int'(a & b); z = (r == 0); n = 0; h = 1; c = 0; end
            4'h6: begin r = int'(a | b); z = (r == 0); n = 0; h = 0; c = 0; end
            4'h7: begin r = int'(a ^ b); z = (r == 0); n = 0; h = 0; c = 0; end
            4'h8: begin r = (int'(a) + 1) & 255; z = (r == 0); n = 0; h = ((r & 15) == 0); end
            4'h9: begin r = (int'(a) + 255) & 255; z = (r == 0); n = 1; h = ((r & 15) == 15); end
            4'hA: begin r = int'(~a); n = 1; h = 1; end
            4'hB: begin n = 0; h = 0; c = 1; end
            4'hC: begin n = 0; h = 0; c = 1 - c; end
            default: hit = 1'b0;
        endcase
        return {hit, 8'(r), 1'(z), 1'(n), 1'(h), 1'(c), 4'h0};
    endfunction

    task automatic run_op(input string tag, input bit valid, input logic [3:0] code,
                          input logic [7:0] a, input logic [7:0] b);
        logic [16:0] m;
        @(negedge clk);
        op_valid = valid; op_code = code; acc_in = a; opnd_in = b;
        m = model(code, a, b, exp_flg);
        if (valid && m[16]) begin
            exp_res = m[15:8];
            exp_flg = m[7:0];
        end
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, "result", result_q, exp_res);
        check(tag, "flags", flags_q, exp_flg);
    endtask

    task automatic pop_flags(input logic [7:0] v);
        @(negedge clk);
        flag_pop = 1'b1; flag_pop_byte = v;
        exp_flg = {v[7:4], 4'h0};
        @(negedge clk);
        flag_pop = 1'b0;
        check("R11", "popped flags", flags_q, exp_flg);
        check("R1", "low nibble", flags_q & 8'h0F, 8'h00);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_res = 8'h00; exp_flg = 8'h00;
        check("R1", "reset result", result_q, 8'h00);
        check("R1", "reset flags", flags_q, 8'h00);
    endtask

    task automatic t_add();
        run_op("R2", 1, 4'h0, 8'h0F, 8'h01);
        check("R2", "half carry 0x10", flags_q, 8'h20);
        run_op("R2", 1, 4'h0, 8'h80, 8'h80);
        check("R2", "zero+carry", flags_q, 8'h90);
        run_op("R2", 1, 4'h0, 8'h12, 8'h34);
    endtask

    task automatic t_adc();
        run_op("R3", 1, 4'hB, 8'h00, 8'h00);
        run_op("R3", 1, 4'h1, 8'h00, 8'hFF);
        check("R3", "carry-in wrap result", result_q, 8'h00);
        check("R3", "carry-in wrap flags", flags_q, 8'hB0);
        run_op("R3", 1, 4'h1, 8'h10, 8'h20);
    endtask

    task automatic t_sub();
        pop_flags(8'h10);
        run_op("R4", 1, 4'h3, 8'h00, 8'hFF);
        check("R4", "borrow wrap result", result_q, 8'h00);
        check("R4", "borrow wrap flags", flags_q, 8'hF0);
        run_op("R4", 1, 4'h2, 8'h10, 8'h01);
        check("R4", "nibble borrow", flags_q, 8'h60);
        run_op("R4", 1, 4'h2, 8'h42, 8'h42);
    endtask

    task automatic t_cmp();
        run_op("R5", 1, 4'h0, 8'h01, 8'h01);
        run_op("R5", 1, 4'h4, 8'h33, 8'h33);
        check("R5", "cmp equal keeps acc", result_q, 8'h33);
        run_op("R5", 1, 4'h4, 8'h05, 8'h10);
        check("R5", "cmp less flags", flags_q, 8'h50);
    endtask

    task automatic t_logic();
        run_op("R6", 1, 4'h5, 8'hF0, 8'h0F);
        check("R6", "and zero", flags_q, 8'hA0);
        run_op("R6", 1, 4'h6, 8'h00, 8'h00);
        run_op("R6", 1, 4'h7, 8'hAA, 8'h55);
        check("R6", "xor result", result_q, 8'hFF);
    endtask

    task automatic t_incdec();
        run_op("R7", 1, 4'hB, 8'h00, 8'h00);
        run_op("R7", 1, 4'h8, 8'hFF, 8'h00);
        check("R7", "inc wrap keeps C", flags_q, 8'hB0);
        run_op("R7", 1, 4'hC, 8'h00, 8'h00);
        run_op("R7", 1, 4'h8, 8'h3F, 8'h00);
        run_op("R8", 1, 4'h9, 8'h10, 8'h00);
        check("R8", "dec low nibble F", flags_q, 8'h60);
        run_op("R8", 1, 4'h9, 8'h01, 8'h00);
    endtask

    task automatic t_cpl_carry();
        run_op("R9", 1, 4'h0, 8'h00, 8'h00);
        run_op("R9", 1, 4'hA, 8'h5A, 8'h00);
        check("R9", "cpl result", result_q, 8'hA5);
        check("R9", "cpl flags keep Z", flags_q, 8'hE0);
        run_op("R10", 1, 4'hB, 8'h77, 8'h00);
        check("R10", "scf flags", flags_q, 8'h90);
        run_op("R10", 1, 4'hC, 8'h77, 8'h00);
        check("R10", "ccf flags", flags_q, 8'h80);
        run_op("R10", 1, 4'hC, 8'h66, 8'h00);
    endtask

    task automatic t_pop();
        pop_flags(8'hAB);
        pop_flags(8'h5F);
        // pop in the same cycle as an operation: op ignored
        @(negedge clk);
        flag_pop = 1'b1; flag_pop_byte = 8'h3C;
        op_valid = 1'b1; op_code = 4'h0; acc_in = 8'h11; opnd_in = 8'h22;
        exp_flg = 8'h30;
        @(negedge clk);
        flag_pop = 1'b0; op_valid = 1'b0;
        check("R11", "pop wins flags", flags_q, exp_flg);
        check("R11", "pop holds result", result_q, exp_res);
    endtask

    task automatic t_idle();
        run_op("R12", 1, 4'h6, 8'h81, 8'h00);
        run_op("R12", 0, 4'h0, 8'hFF, 8'h01);
        run_op("R12", 1, 4'hD, 8'h00, 8'h00);
        run_op("R12", 1, 4'hE, 8'h12, 8'h34);
        run_op("R12", 1, 4'hF, 8'hFF, 8'hFF);
    endtask

    task automatic t_sweep();
        for (int code = 0; code < 13; code++) begin
            for (int a = 0; a < 256; a += 17) begin
                for (int b = 0; b < 256; b += 51) begin
                    run_op("R2-sweep", 1, 4'(code), 8'(a), 8'(b));
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_cmp();
        t_logic();
        t_incdec();
        t_cpl_carry();
        t_pop();
        t_idle();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule